// File: doc/BRIEF.md
# Sequential Nonrestoring Divider

This block divides an unsigned numerator by an unsigned denominator of the same width and produces a quotient and a remainder. It works one quotient digit per clock. In each step the partial remainder is shifted left, the next numerator bit is brought in, and the denominator is then subtracted or added. The choice depends only on the sign that the partial remainder had before the step. The block never undoes an operation inside a step.

Every quotient digit is +1 or -1. The digits are kept in a plain bit register, with 1 meaning +1 and 0 meaning -1. After the last step a single fix-up cycle does two things. It converts the stored word P to two's complement as 2·P − (2^W − 1). If the last partial remainder is negative, it also adds the denominator back to the remainder and subtracts one from the quotient.

A caller pulses `start` with both operands while the block is idle. It then waits for the one-cycle `done` pulse and reads the results. A zero denominator produces a flag and a fixed result, not an arithmetic answer.

Top module: `nrdiv_top`

## Requirements
- R1: While `rst` is high at a rising edge, and in the first cycle after it, `busy`, `done` and `div0` are 0, and `quo` and `rem` are 0.
- R2: A `start` that is high at a rising edge while `busy` is low is accepted. `busy` is then 1 from the next cycle until the result cycle.
- R3: `done` goes high for exactly one cycle, W+1 clock edges after the accepting edge. `busy` is 0 in that cycle.
- R4: For a nonzero denominator, the results satisfy num = quo·den + rem with 0 ≤ rem < den, for the operands taken at the accepting edge.
- R5: A `start` that arrives while `busy` is high is ignored, and the running division finishes with its original operands.
- R6: When the last step leaves the partial remainder negative, the result is still exact. For example, 5/9 gives quotient 0 and remainder 5, and 37/6 gives quotient 6 and remainder 1.
- R7: A zero denominator sets `div0` in the result cycle, returns an all-ones quotient, and returns the numerator as the remainder. `div0` clears on the next division whose denominator is nonzero.
- R8: `quo`, `rem` and `div0` change only in a cycle in which `done` is high. Input changes while the block is idle leave them unchanged.
- R9: A `start` given in the `done` cycle is accepted, so divisions can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a division; only sampled while idle |
| num | input | W | Unsigned numerator |
| den | input | W | Unsigned denominator |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse marking valid results |
| quo | output | W | Quotient |
| rem | output | W | Remainder |
| div0 | output | 1 | Last result came from a zero denominator |

## Verification
The bound checker captures the operands at each accepted start. On every cycle it checks the division identity and the remainder bound on each result, the single-cycle `done` pulse and its W+1 latency, the zero-denominator result, and that the outputs hold outside `done`.

Only the bench scenarios can show the following:
- that particular operand pairs give the expected quotient;
- that the correction path is reached at all;
- that a start arriving mid-run is really dropped;
- that a start in the `done` cycle really launches the next division.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_FIX  = 2'd2
    } nrdiv_state_e;

    typedef enum logic {
        OP_SUB = 1'b0,
        OP_ADD = 1'b1
    } nrdiv_op_e;

    // A non-negative partial remainder is followed by a subtraction,
    // a negative one by an addition.
    function automatic nrdiv_op_e pick_op(input logic rem_negative);
        return rem_negative ? OP_ADD : OP_SUB;
    endfunction

endpackage

// File: rtl/nrdiv_step.sv
module nrdiv_step
    import nrdiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W:0]   rem_in,
    input  logic         next_bit,
    input  logic [W-1:0] den,
    output logic [W:0]   rem_out,
    output logic         digit_pos
);
    localparam int XW = W + 2;

    nrdiv_op_e       op;
    logic [XW-1:0]   shifted;
    logic [XW-1:0]   dext;
    logic [XW-1:0]   res;

    always_comb begin
        op       = pick_op(rem_in[W]);
        // 2*r + bit; the partial remainder's sign bit becomes the new MSB
        shifted  = {rem_in, next_bit};
        dext     = {2'b00, den};
        res      = (op == OP_SUB) ? (shifted - dext) : (shifted + dext);
        // the result lies in [-den, den), so W+1 bits hold it
        rem_out  = res[W:0];
        digit_pos = (op == OP_SUB);
    end

endmodule

// File: rtl/nrdiv_fix.sv
module nrdiv_fix #(
    parameter int W = 8
) (
    input  logic [W-1:0] digits,
    input  logic [W:0]   rem_raw,
    input  logic [W-1:0] den,
    input  logic [W-1:0] num,
    input  logic         den_zero,
    output logic [W-1:0] quo_out,
    output logic [W-1:0] rem_out
);
    localparam logic [W:0] ALL_DIGITS = {1'b0, {W{1'b1}}};

    logic [W:0] q_conv;
    logic [W:0] q_adj;
    logic [W:0] r_adj;

    always_comb begin
        // positive-one word minus negative-one word = 2P - (2^W - 1)
        q_conv = {digits, 1'b0} - ALL_DIGITS;
        if (rem_raw[W]) begin
            q_adj = q_conv - {{W{1'b0}}, 1'b1};
            r_adj = rem_raw + {1'b0, den};
        end else begin
            q_adj = q_conv;
            r_adj = rem_raw;
        end
        if (den_zero) begin
            quo_out = {W{1'b1}};
            rem_out = num;
        end else begin
            quo_out = q_adj[W-1:0];
            rem_out = r_adj[W-1:0];
        end
    end

endmodule

// File: rtl/nrdiv_top.sv
module nrdiv_top
    import nrdiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         div0
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    nrdiv_state_e st;
    logic [CW-1:0] step_cnt;
    logic [W:0]    prem;
    logic [W-1:0]  digits;
    logic [W-1:0]  num_sh;
    logic [W-1:0]  num_q;
    logic [W-1:0]  den_q;

    logic [W:0]    prem_nx;
    logic          dig_nx;
    logic [W-1:0]  quo_fix;
    logic [W-1:0]  rem_fix;
    logic          den_zero;

    assign den_zero = (den_q == '0);

    nrdiv_step #(.W(W)) u_step (
        .rem_in    (prem),
        .next_bit  (num_sh[W-1]),
        .den       (den_q),
        .rem_out   (prem_nx),
        .digit_pos (dig_nx)
    );

    nrdiv_fix #(.W(W)) u_fix (
        .digits   (digits),
        .rem_raw  (prem),
        .den      (den_q),
        .num      (num_q),
        .den_zero (den_zero),
        .quo_out  (quo_fix),
        .rem_out  (rem_fix)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            step_cnt <= '0;
            prem     <= '0;
            digits   <= '0;
            num_sh   <= '0;
            num_q    <= '0;
            den_q    <= '0;
            busy     <= 1'b0;
            done     <= 1'b0;
            quo      <= '0;
            rem      <= '0;
            div0     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        prem     <= '0;
                        digits   <= '0;
                        num_sh   <= num;
                        num_q    <= num;
                        den_q    <= den;
                        step_cnt <= '0;
                        busy     <= 1'b1;
                        st       <= ST_ITER;
                    end
                end
                ST_ITER: begin
                    prem     <= prem_nx;
                    digits   <= {digits[W-2:0], dig_nx};
                    num_sh   <= {num_sh[W-2:0], 1'b0};
                    step_cnt <= step_cnt + 1'b1;
                    if (step_cnt == LAST_STEP) begin
                        st <= ST_FIX;
                    end
                end
                ST_FIX: begin
                    quo  <= quo_fix;
                    rem  <= rem_fix;
                    div0 <= den_zero;
                    done <= 1'b1;
                    busy <= 1'b0;
                    st   <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nrdiv_chk.sv
module nrdiv_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [W-1:0] num,
    input logic [W-1:0] den,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quo,
    input logic [W-1:0] rem,
    input logic         div0
);
    localparam int LW = $clog2(W + 3) + 1;

    logic [W-1:0]   n_cap;
    logic [W-1:0]   d_cap;
    logic [LW-1:0]  lat;
    logic [2*W-1:0] recon;

    always_ff @(posedge clk) begin
        if (rst) begin
            n_cap <= '0;
            d_cap <= '0;
            lat   <= '0;
        end else if (start && !busy) begin
            n_cap <= num;
            d_cap <= den;
            lat   <= '0;
        end else if (busy) begin
            lat <= lat + 1'b1;
        end
    end

    assign recon = ({{W{1'b0}}, quo} * {{W{1'b0}}, d_cap}) + {{W{1'b0}}, rem};

    a_r2_accept: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r3_idle_at_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    a_r3_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat == LW'(W + 1)));
    a_r4_identity: assert property (@(posedge clk) disable iff (rst)
        (done && d_cap != '0) |-> (recon == {{W{1'b0}}, n_cap}));
    a_r4_rem_bound: assert property (@(posedge clk) disable iff (rst)
        (done && d_cap != '0) |-> (rem < d_cap && !div0));
    a_r7_zero_den: assert property (@(posedge clk) disable iff (rst)
        (done && d_cap == '0) |-> (div0 && quo == {W{1'b1}} && rem == n_cap));
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(quo) && $stable(rem) && $stable(div0)));

endmodule

bind nrdiv_top nrdiv_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .num   (num),
    .den   (den),
    .busy  (busy),
    .done  (done),
    .quo   (quo),
    .rem   (rem),
    .div0  (div0)
);

// File: tb/sim_nrdiv_top.sv
module sim_nrdiv_top;
    localparam int W = 8;
    localparam int NV = 10;
    // {num, den, expected quotient, expected remainder}
    localparam logic [31:0] VEC [NV] = '{
        {8'd200, 8'd7,   8'd28,  8'd4},
        {8'd255, 8'd1,   8'd255, 8'd0},
        {8'd255, 8'd255, 8'd1,   8'd0},
        {8'd0,   8'd5,   8'd0,   8'd0},
        {8'd5,   8'd9,   8'd0,   8'd5},
        {8'd100, 8'd10,  8'd10,  8'd0},
        {8'd173, 8'd16,  8'd10,  8'd13},
        {8'd254, 8'd127, 8'd2,   8'd0},
        {8'd129, 8'd128, 8'd1,   8'd1},
        {8'd37,  8'd6,   8'd6,   8'd1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [W-1:0] num = '0;
    logic [W-1:0] den = '0;
    logic busy, done, div0;
    logic [W-1:0] quo, rem;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    nrdiv_top #(.W(W)) u0 (
        .clk(clk), .rst(rst), .start(start), .num(num), .den(den),
        .busy(busy), .done(done), .quo(quo), .rem(rem), .div0(div0)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge where done is seen.
    task automatic run(input logic [W-1:0] n, input logic [W-1:0] d, output int lat);
        num = n;
        den = d;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        chk(busy == 1'b1, "R2", int'(busy), 1);
        while (!done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int lat;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && div0 == 1'b0, "R1", {busy, done, div0}, 0);
        chk(quo == '0 && rem == '0, "R1", {quo, rem}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1", {busy, done}, 0);

        // table walk, back to back
        for (int i = 0; i < NV; i++) begin
            run(VEC[i][31:24], VEC[i][23:16], lat);
            chk(lat == W + 1, "R3", lat, W + 1);
            chk(busy == 1'b0, "R3", int'(busy), 0);
            chk(quo == VEC[i][15:8], "R4", int'(quo), int'(VEC[i][15:8]));
            chk(rem == VEC[i][7:0], "R4", int'(rem), int'(VEC[i][7:0]));
            chk(div0 == 1'b0, "R4", int'(div0), 0);
            if (i == 4 || i == 9)
                chk(quo == VEC[i][15:8] && rem == VEC[i][7:0], "R6", int'(quo), int'(VEC[i][15:8]));
        end

        // done is a single cycle
        @(negedge clk);
        chk(done == 1'b0, "R3", int'(done), 0);

        // zero denominator
        run(8'd77, 8'd0, lat);
        chk(div0 == 1'b1, "R7", int'(div0), 1);
        chk(quo == 8'hFF, "R7", int'(quo), 255);
        chk(rem == 8'd77, "R7", int'(rem), 77);

        // back to back straight from the done cycle, div0 clears
        num = 8'd9;
        den = 8'd3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9", int'(busy), 1);
        lat = 0;
        while (!done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        chk(quo == 8'd3 && rem == 8'd0, "R9", int'(quo), 3);
        chk(div0 == 1'b0, "R7", int'(div0), 0);

        // outputs hold while idle
        @(negedge clk);
        num = 8'd11;
        den = 8'd2;
        repeat (4) @(negedge clk);
        chk(quo == 8'd3 && rem == 8'd0 && done == 1'b0, "R8", int'(quo), 3);

        // start during busy is dropped
        num = 8'd50;
        den = 8'd5;
        start = 1'b1;
        @(negedge clk);
        num = 8'd99;
        den = 8'd2;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == W + 1, "R5", lat, W + 1);
        chk(quo == 8'd10 && rem == 8'd0, "R5", int'(quo), 10);
        @(negedge clk);
        chk(busy == 1'b0, "R5", int'(busy), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule